// File: doc/BRIEF.md
# Dual-Core External Interrupt Router

This block watches a set of asynchronous external lines. On each line it detects a trigger edge, and the edge can be falling, rising or both. Each of two processor cores gets its own interrupt request and its own event pulse from the block. Every line carries four independent enables: one interrupt enable and one event enable for each core. Because of this, one core can own a line while the other core ignores it, or both cores can take the line. Each core keeps its own pending bits, and each core clears its own pending bits without touching the other core's.

Software configures the block through a small synchronous register port. The port has a lock. While the lock is engaged, writes to the enable and trigger registers are dropped. Software releases the lock by writing a key value to the lock register, and engages it again by writing any other value. Pending bits are cleared by writing ones to a core's pending register, and these clears work whether or not the lock is engaged.

Top module: `exti_dual_router`

## Requirements
- R1: Register addresses are: 0 lock, 1 core-0 interrupt enable, 2 core-1 interrupt enable, 3 core-0 event enable, 4 core-1 event enable, 5 trigger select, 6 core-0 pending, 7 core-1 pending. `reg_rdata` returns the register at `reg_addr` one clock after the address is presented. Unused upper bits read as 0.
- R2: The lock is engaged after reset. Writing the key 0x00005AC3 to address 0 releases it. Writing any other value to address 0 engages it again. Reading address 0 returns 1 in bit 0 while the lock is released.
- R3: While the lock is engaged, writes to addresses 1 to 5 are ignored and the registers keep their values.
- R4: Trigger select holds a 2-bit code for line i at bits [2i+1:2i]. Code 00 selects the falling edge, 01 the rising edge, and 10 or 11 both edges.
- R5: Each line passes through a two-flop synchroniser. A level change that is set up before rising edge k is seen on `irq_o` and `evt_o` just after rising edge k+2, and not before.
- R6: A core's pending bit for a line is set on a detected edge only if that core's interrupt-enable bit for the line is 1 at that edge.
- R7: A pending bit stays set until its own core writes a 1 to it at address 6 or 7. A clear for one core leaves the other core's bits unchanged. Clears work while the lock is engaged. An edge that arrives in the same cycle as a clear leaves the bit set.
- R8: `irq_o[c]` is high while core c has any pending bit whose interrupt enable is 1. It is updated in the same cycle as the pending bits.
- R9: `evt_o[c]` pulses for one cycle for each cycle in which a detected edge falls on a line whose core-c event-enable bit is 1. An event sets no pending bit.
- R10: After reset, all enables, all pending bits, the trigger codes and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | NUM_LINES | Asynchronous external lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_o | output | 2 | Interrupt request, one per core |
| evt_o | output | 2 | Event pulse, one per core |

## Verification
Directed patterns come first.
- A single falling edge is sent to a line enabled for only one core. This separates per-core interrupt routing from a shared status.
- A rising edge is timed cycle by cycle. This checks the synchroniser latency and shows that the event pulse lasts one cycle.
- An edge is sent on a line that has only an event enable. This shows that events and pending status are kept apart.

A long random phase follows. It toggles lines under all three trigger codes. It mixes in writes while the lock is engaged, lock changes, cross-core clears and clears that land on the same cycle as an edge. A behavioural model is compared against the design on every clock.

// File: rtl/exti_pkg.sv
package exti_pkg;
  localparam int NC = 2;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_LOCK    = 3'd0;
  localparam logic [AW-1:0] A_IM_BASE = 3'd1;
  localparam logic [AW-1:0] A_EM_BASE = 3'd3;
  localparam logic [AW-1:0] A_TRIG    = 3'd5;
  localparam logic [AW-1:0] A_PD_BASE = 3'd6;

  typedef enum logic [1:0] {
    TRIG_FALL = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_BOTH = 2'b10
  } trig_e;
endpackage

// File: rtl/exti_edge_detect.sv
module exti_edge_detect #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   line_i,
  input  logic [2*N-1:0] trig,
  output logic [N-1:0]   hit
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_line
      logic s1, s2, s3;
      logic rise, fall;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1 <= 1'b0;
          s2 <= 1'b0;
          s3 <= 1'b0;
        end else begin
          s1 <= line_i[i];
          s2 <= s1;
          s3 <= s2;
        end
      end
      assign rise = s2 & ~s3;
      assign fall = ~s2 & s3;
      always_comb begin
        case (trig[2*i +: 2])
          2'b00:   hit[i] = fall;
          2'b01:   hit[i] = rise;
          default: hit[i] = rise | fall;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/exti_cfg_regs.sv
module exti_cfg_regs
  import exti_pkg::*;
#(
  parameter int          N    = 8,
  parameter int          DW   = 32,
  parameter logic [31:0] KEY  = 32'h0000_5AC3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic [NC-1:0][N-1:0] pend,
  output logic [NC-1:0][N-1:0] imask,
  output logic [NC-1:0][N-1:0] emask,
  output logic [NC-1:0][N-1:0] clr,
  output logic [2*N-1:0]       trig,
  output logic [DW-1:0]        rdata
);
  logic          unlocked;
  logic [DW-1:0] rd_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      trig     <= '0;
    end else if (we) begin
      if (addr == A_LOCK) unlocked <= (wdata == DW'(KEY));
      if (addr == A_TRIG && unlocked) trig <= wdata[2*N-1:0];
    end
  end

  genvar c;
  generate
    for (c = 0; c < NC; c++) begin : g_core
      localparam logic [AW-1:0] AIM = A_IM_BASE + AW'(c);
      localparam logic [AW-1:0] AEM = A_EM_BASE + AW'(c);
      localparam logic [AW-1:0] APD = A_PD_BASE + AW'(c);
      always_ff @(posedge clk) begin
        if (rst) begin
          imask[c] <= '0;
          emask[c] <= '0;
        end else if (we && unlocked) begin
          if (addr == AIM) imask[c] <= wdata[N-1:0];
          if (addr == AEM) emask[c] <= wdata[N-1:0];
        end
      end
      assign clr[c] = (we && addr == APD) ? wdata[N-1:0] : '0;
    end
  endgenerate

  always_comb begin
    rd_d = '0;
    case (addr)
      A_LOCK:        rd_d[0]       = unlocked;
      A_IM_BASE:     rd_d[N-1:0]   = imask[0];
      A_IM_BASE + 1: rd_d[N-1:0]   = imask[1];
      A_EM_BASE:     rd_d[N-1:0]   = emask[0];
      A_EM_BASE + 1: rd_d[N-1:0]   = emask[1];
      A_TRIG:        rd_d[2*N-1:0] = trig;
      A_PD_BASE:     rd_d[N-1:0]   = pend[0];
      default:       rd_d[N-1:0]   = pend[1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end

  // R3: a write attempted while locked leaves the enable unchanged
  a_r3_locked_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_IM_BASE && !unlocked) |=> $stable(imask[0]));
  // R2: a non-key write to the lock register leaves it engaged
  a_r2_wrong_key_locks: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_LOCK && wdata != DW'(KEY)) |=> !unlocked);
endmodule

// File: rtl/exti_core_route.sv
module exti_core_route #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] imask,
  input  logic [N-1:0] emask,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend,
  output logic         irq,
  output logic         evt
);
  logic [N-1:0] pend_d;

  assign pend_d = (pend & ~clr) | (hit & imask);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      irq  <= 1'b0;
      evt  <= 1'b0;
    end else begin
      pend <= pend_d;
      irq  <= |(pend_d & imask);
      evt  <= |(hit & emask);
    end
  end

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_chk
      // R6: no pending bit appears while its interrupt enable is 0
      a_r6_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (!pend[i] && !imask[i]) |=> !pend[i]);
      // R7: a pending bit holds until its own clear
      a_r7_hold_until_clear: assert property (@(posedge clk) disable iff (rst)
        (pend[i] && !clr[i]) |=> pend[i]);
    end
  endgenerate

  // R9: an event pulse needs an event enable on the previous cycle
  a_r9_evt_needs_enable: assert property (@(posedge clk) disable iff (rst)
    evt |-> $past(|emask));
  // R8: a request implies some pending bit
  a_r8_irq_has_pending: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|pend));
endmodule

// File: rtl/exti_dual_router.sv
module exti_dual_router
  import exti_pkg::*;
#(
  parameter int          NUM_LINES = 8,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] UNLOCK_KEY = 32'h0000_5AC3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 reg_we,
  input  logic [2:0]           reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [1:0]           irq_o,
  output logic [1:0]           evt_o
);
  logic [NUM_LINES-1:0]          hit;
  logic [2*NUM_LINES-1:0]        trig;
  logic [NC-1:0][NUM_LINES-1:0]  imask, emask, clr, pend;

  exti_edge_detect #(.N(NUM_LINES)) edge_i (
    .clk(clk), .rst(rst), .line_i(line_i), .trig(trig), .hit(hit)
  );

  exti_cfg_regs #(.N(NUM_LINES), .DW(DATA_W), .KEY(UNLOCK_KEY)) cfg_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .pend(pend), .imask(imask), .emask(emask), .clr(clr), .trig(trig),
    .rdata(reg_rdata)
  );

  genvar c;
  generate
    for (c = 0; c < NC; c++) begin : g_route
      exti_core_route #(.N(NUM_LINES)) route_i (
        .clk(clk), .rst(rst), .hit(hit), .imask(imask[c]), .emask(emask[c]),
        .clr(clr[c]), .pend(pend[c]), .irq(irq_o[c]), .evt(evt_o[c])
      );
    end
  endgenerate
endmodule

// File: tb/exti_dual_router_tb.sv
`timescale 1ns/1ps
module exti_dual_router_tb_top;
  localparam int N = 8;
  localparam int DW = 32;
  localparam logic [31:0] KEY = 32'h0000_5AC3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] line_i = '0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [1:0] irq_o, evt_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  exti_dual_router #(.NUM_LINES(N), .DATA_W(DW), .UNLOCK_KEY(KEY)) dut_i (
    .clk(clk), .rst(rst), .line_i(line_i), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .evt_o(evt_o)
  );

  // behavioural reference model
  logic [N-1:0] ms1, ms2, ms3;
  logic [N-1:0] m_im [2];
  logic [N-1:0] m_em [2];
  logic [N-1:0] m_pd [2];
  logic [2*N-1:0] m_trig;
  logic m_unl;
  logic [1:0] m_irq, m_evt;
  logic [DW-1:0] m_rd;

  always @(posedge clk) begin
    logic [N-1:0] h, np0, np1, c0, c1;
    if (rst) begin
      ms1 = '0; ms2 = '0; ms3 = '0;
      m_im[0] = '0; m_im[1] = '0; m_em[0] = '0; m_em[1] = '0;
      m_pd[0] = '0; m_pd[1] = '0; m_trig = '0; m_unl = 0;
      m_irq = '0; m_evt = '0; m_rd = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        logic f, r;
        f = ms3[i] && !ms2[i];
        r = !ms3[i] && ms2[i];
        case (m_trig[2*i +: 2])
          2'b00: h[i] = f;
          2'b01: h[i] = r;
          default: h[i] = f | r;
        endcase
      end
      m_rd = '0;
      case (reg_addr)
        3'd0: m_rd[0] = m_unl;
        3'd1: m_rd[N-1:0] = m_im[0];
        3'd2: m_rd[N-1:0] = m_im[1];
        3'd3: m_rd[N-1:0] = m_em[0];
        3'd4: m_rd[N-1:0] = m_em[1];
        3'd5: m_rd[2*N-1:0] = m_trig;
        3'd6: m_rd[N-1:0] = m_pd[0];
        default: m_rd[N-1:0] = m_pd[1];
      endcase
      c0 = (reg_we && reg_addr == 3'd6) ? reg_wdata[N-1:0] : '0;
      c1 = (reg_we && reg_addr == 3'd7) ? reg_wdata[N-1:0] : '0;
      np0 = (m_pd[0] & ~c0) | (h & m_im[0]);
      np1 = (m_pd[1] & ~c1) | (h & m_im[1]);
      m_irq = {|(np1 & m_im[1]), |(np0 & m_im[0])};
      m_evt = {|(h & m_em[1]), |(h & m_em[0])};
      m_pd[0] = np0; m_pd[1] = np1;
      if (reg_we) begin
        if (reg_addr == 3'd0) m_unl = (reg_wdata == KEY);
        else if (m_unl) begin
          case (reg_addr)
            3'd1: m_im[0] = reg_wdata[N-1:0];
            3'd2: m_im[1] = reg_wdata[N-1:0];
            3'd3: m_em[0] = reg_wdata[N-1:0];
            3'd4: m_em[1] = reg_wdata[N-1:0];
            3'd5: m_trig = reg_wdata[2*N-1:0];
            default: ;
          endcase
        end
      end
      ms3 = ms2; ms2 = ms1; ms1 = line_i;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R8 irq_o", {30'd0, irq_o}, {30'd0, m_irq});
      chk("R9 evt_o", {30'd0, evt_o}, {30'd0, m_evt});
      chk("R1 reg_rdata", reg_rdata, m_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 irq reset", {30'd0, irq_o}, 32'd0);
    chk("R10 evt reset", {30'd0, evt_o}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R10 reg reset", v, 32'd0);
    end
    // R3 locked write ignored
    wr(3'd1, 32'hFF);
    rd(3'd1, v);
    chk("R3 locked enable write", v, 32'd0);
    // R2 unlock
    wr(3'd0, KEY);
    rd(3'd0, v);
    chk("R2 unlock readback", v, 32'd1);
    wr(3'd1, 32'h03);
    wr(3'd2, 32'h06);
    wr(3'd3, 32'h02);
    wr(3'd4, 32'h84);
    wr(3'd5, 32'h24);
    rd(3'd5, v);
    chk("R4 trigger readback", v, 32'h24);
    // R6 falling edge on line0 reaches core0 only
    @(negedge clk); line_i[0] = 1'b1;
    repeat (4) @(negedge clk); line_i[0] = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd6, v);
    chk("R6 core0 pending", v, 32'h01);
    rd(3'd7, v);
    chk("R6 core1 pending", v, 32'h00);
    chk("R8 irq core0 only", {30'd0, irq_o}, 32'd1);
    // R5 / R9 timing of rising edge on line1
    @(negedge clk); line_i[1] = 1'b1;
    @(negedge clk); chk("R5 no evt after k", {30'd0, evt_o}, 32'd0);
    @(negedge clk); chk("R5 no evt after k+1", {30'd0, evt_o}, 32'd0);
    @(negedge clk); chk("R5 evt after k+2", {30'd0, evt_o}, 32'd1);
    @(negedge clk); chk("R9 evt single cycle", {30'd0, evt_o}, 32'd0);
    rd(3'd7, v);
    chk("R6 core1 pending line1", v, 32'h02);
    // R7 clear core0 leaves core1
    wr(3'd0, 32'h0);
    wr(3'd6, 32'hFF);
    rd(3'd6, v);
    chk("R7 core0 cleared while locked", v, 32'h00);
    rd(3'd7, v);
    chk("R7 core1 untouched", v, 32'h02);
    // R9 event-only line7 sets no pending
    @(negedge clk); line_i[7] = 1'b1;
    repeat (4) @(negedge clk); line_i[7] = 1'b0;
    repeat (2) @(negedge clk);
    @(negedge clk); chk("R9 evt core1 line7", {30'd0, evt_o}, 32'd2);
    rd(3'd7, v);
    chk("R9 no pending from event", v, 32'h02);
    wr(3'd3, 32'hFF);
    rd(3'd3, v);
    chk("R3 locked event write", v, 32'h02);
    // random phase, model compared every clock
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      line_i = ($urandom_range(0, 2) == 0) ? N'($urandom) : line_i;
      reg_we = 1'b0;
      reg_addr = 3'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        reg_we = 1'b1;
        reg_wdata = $urandom;
        if (reg_addr == 3'd0 && $urandom_range(0, 1) == 0) reg_wdata = KEY;
      end
    end
    @(negedge clk); reg_we = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule